// File: doc/BRIEF.md
# DC-only 8x8 block summer

This block produces only the DC term of a forward 2-D transform for an 8x8 block of signed 16-bit samples. A block enters one row per clock, all eight samples of a row side by side on a single wide bus. The first row of a block carries a start marker. Each of the eight lanes keeps a running 16-bit column total, and that total wraps when it overflows. When the last row of a block is taken in, the eight column totals are sign-extended and added in a wider adder tree. The low 16 bits of that sum are then presented as the DC coefficient.

The result goes out as two words under one valid strobe. The first word is the DC value and the second word is always zero. A transform pipeline uses this as a fast path when only the mean of a block is needed. No scaling or saturation is applied anywhere.

Top module: `dcsum8x8`

## Requirements
- R1: While reset is asserted and after it is released, `res_valid` stays low until a complete block has been taken in.
- R2: Each lane i (bits [16i+15:16i] of `in_row`) loads its sample from the start-marked row, then adds the samples of each later row of the block. The addition is 16-bit with two's-complement wraparound.
- R3: The eight 16-bit column totals are sign-extended and added in at least 19-bit precision. `res_dc` is the low 16 bits of that sum.
- R4: `res_zero` is 0 whenever `res_valid` is high.
- R5: `res_valid` is high for exactly the one cycle that follows the clock edge that accepts the eighth row of a block. At all other times it is low.
- R6: A row with `in_valid` and `in_sop` both high always starts a new block. It does so even while an earlier block is partly collected, and the partial data of that earlier block is discarded.
- R7: Cycles with `in_valid` low leave the block state unchanged, so the rows of a block may arrive with gaps between them.
- R8: A valid row without `in_sop` is ignored when no block is open. No block is open after reset, and none is open after the eighth row of a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | A row is present on `in_row` this cycle |
| in_sop | input | 1 | The present row is the first row of a block |
| in_row | input | 128 | Eight signed 16-bit samples; lane i sits at bits [16i+15:16i] |
| res_valid | output | 1 | One-cycle strobe qualifying the result words |
| res_dc | output | 16 | DC coefficient: low 16 bits of the sum of the column totals |
| res_zero | output | 16 | Second coefficient, always zero |

## Verification
The result is due in the cycle that directly follows the edge that takes in the eighth row. Nothing else in the block has latency: loads, additions and dropped rows all take effect at the edge where they are presented. The bench drives inputs on the falling edge and waits for the rising edge. It samples 1 ns after that edge and compares against a reference model updated for that same edge. Every cycle is therefore checked for the exact position of the strobe, as well as for its value. The stimulus includes gaps, dropped rows, restarts and back-to-back blocks, so the strobe position is checked under each of those patterns.

// File: rtl/dcsum_pkg.sv
package dcsum_pkg;
  localparam int unsigned DCS_LANES = 8;
  localparam int unsigned DCS_ROWS  = 8;
  localparam int unsigned DCS_W     = 16;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } fill_st_e;
endpackage

// File: rtl/dcsum_col_acc.sv
module dcsum_col_acc #(
  parameter int unsigned LANES = 8,
  parameter int unsigned W     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               add,
  input  logic [LANES*W-1:0] row_i,
  output logic [LANES*W-1:0] sum_nxt_o
);
  localparam int unsigned VW = LANES * W;

  logic [VW-1:0] acc_q;
  logic [VW-1:0] acc_d;
  logic          acc_en;

  assign acc_en = load | add;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      // wrapping per-lane sum of stored total and incoming sample
      assign sum_nxt_o[g*W +: W] = acc_q[g*W +: W] + row_i[g*W +: W];

      always_comb begin
        if (load) acc_d[g*W +: W] = row_i[g*W +: W];
        else      acc_d[g*W +: W] = sum_nxt_o[g*W +: W];
      end

      // R2
      lane_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> acc_q[g*W +: W] == $past(row_i[g*W +: W]));

      // R2
      lane_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add && !load) |=> acc_q[g*W +: W] ==
          W'($past(acc_q[g*W +: W]) + $past(row_i[g*W +: W])));
    end
  endgenerate

  // datapath register: enable written out, no reset needed on data
  always_ff @(posedge clk) begin
    if (acc_en) acc_q <= acc_d;
  end

  // R7
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !add) |=> $stable(acc_q));
endmodule

// File: rtl/dcsum_tree_reduce.sv
module dcsum_tree_reduce #(
  parameter int unsigned LANES = 8,
  parameter int unsigned W     = 16
) (
  input  logic [LANES*W-1:0]                  col_i,
  output logic [W+$clog2(LANES)-1:0]          total_o
);
  localparam int unsigned SUM_W = W + $clog2(LANES);
  localparam int unsigned NODES = 2 * LANES - 1;

  // heap layout: node k adds nodes 2k+1 and 2k+2; leaves start at LANES-1
  logic [SUM_W-1:0] node [NODES];

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_leaf
      assign node[LANES-1+g] = {{(SUM_W-W){col_i[g*W+W-1]}}, col_i[g*W +: W]};
    end
    for (g = 0; g < LANES - 1; g++) begin : g_node
      assign node[g] = node[2*g+1] + node[2*g+2];
    end
  endgenerate

  assign total_o = node[0];
endmodule

// File: rtl/dcsum8x8.sv
module dcsum8x8
  import dcsum_pkg::*;
#(
  parameter int unsigned LANES = DCS_LANES,
  parameter int unsigned ROWS  = DCS_ROWS,
  parameter int unsigned W     = DCS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_sop,
  input  logic [LANES*W-1:0] in_row,
  output logic               res_valid,
  output logic [W-1:0]       res_dc,
  output logic [W-1:0]       res_zero
);
  localparam int unsigned CNT_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int unsigned SUM_W = W + $clog2(LANES);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ROWS - 1);

  fill_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             vld_q, vld_d;
  logic [W-1:0]     dc_q;

  logic             take_first;
  logic             take_more;
  logic             take_last;
  logic [LANES*W-1:0] col_sum;
  logic [SUM_W-1:0]   total;

  assign take_first = in_valid & in_sop;
  assign take_more  = in_valid & ~in_sop & (st_q == ST_FILL);
  assign take_last  = take_more & (cnt_q == LAST_IDX);

  dcsum_col_acc #(.LANES(LANES), .W(W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (take_first),
    .add       (take_more),
    .row_i     (in_row),
    .sum_nxt_o (col_sum)
  );

  dcsum_tree_reduce #(.LANES(LANES), .W(W)) u_tree (
    .col_i   (col_sum),
    .total_o (total)
  );

  // next-state
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    vld_d = 1'b0;
    if (take_first) begin
      st_d  = ST_FILL;
      cnt_d = CNT_W'(1);
    end else if (take_more) begin
      if (take_last) begin
        st_d  = ST_IDLE;
        cnt_d = '0;
        vld_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      vld_q <= vld_d;
    end
  end

  // result register, loaded only on the closing row
  always_ff @(posedge clk) begin
    if (take_last) dc_q <= total[W-1:0];
  end

  assign res_valid = vld_q;
  assign res_dc    = dc_q;
  assign res_zero  = '0;

  // R5
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R5
  res_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($past(in_valid) && !$past(in_sop)));

  // R6
  sop_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sop) |=> (cnt_q == CNT_W'(1)) && (st_q == ST_FILL) && !res_valid);

  // R8
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && !(in_valid && in_sop)) |=> (st_q == ST_IDLE) && !res_valid);

  // R7
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cnt_q) && $stable(st_q) && !res_valid);
endmodule

// File: tb/tb_dcsum8x8.sv
`timescale 1ns/1ps
module tb_dcsum8x8;
  localparam int LANES = 8;
  localparam int W     = 16;

  logic             clk;
  logic             rst_n;
  logic             in_valid;
  logic             in_sop;
  logic [LANES*W-1:0] in_row;
  logic             res_valid;
  logic [W-1:0]     res_dc;
  logic [W-1:0]     res_zero;

  int n_chk;
  int n_fail;
  bit done;

  // reference model state
  bit          m_open;
  int          m_cnt;
  logic [15:0] m_col [LANES];

  dcsum8x8 dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_row(in_row), .res_valid(res_valid), .res_dc(res_dc), .res_zero(res_zero)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [15:0] ref_dc(input logic [15:0] c [LANES]);
    int acc = 0;
    for (int i = 0; i < LANES; i++) acc += int'($signed(c[i]));
    return acc[15:0];
  endfunction

  function automatic logic [LANES*W-1:0] fill_row(input logic [15:0] v);
    logic [LANES*W-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*W +: W] = v;
    return r;
  endfunction

  function automatic logic [LANES*W-1:0] rand_row();
    logic [LANES*W-1:0] r;
    for (int i = 0; i < LANES; i++) begin
      case ($urandom_range(3))
        0:       r[i*W +: W] = 16'h7FFF - 16'($urandom_range(3));
        1:       r[i*W +: W] = 16'h8000 + 16'($urandom_range(3));
        default: r[i*W +: W] = 16'($urandom);
      endcase
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, sample 1 ns after the rising edge
  task automatic step(input bit v, input bit s, input logic [LANES*W-1:0] r,
                      output logic [15:0] dc_seen);
    bit          exp_v = 1'b0;
    logic [15:0] exp_dc = '0;
    @(negedge clk);
    in_valid = v; in_sop = s; in_row = r;
    if (v && s) begin
      for (int i = 0; i < LANES; i++) m_col[i] = r[i*W +: W];
      m_cnt = 1; m_open = 1'b1;
    end else if (v && m_open) begin
      for (int i = 0; i < LANES; i++) m_col[i] = m_col[i] + r[i*W +: W];
      m_cnt++;
      if (m_cnt == 8) begin
        exp_v = 1'b1; exp_dc = ref_dc(m_col); m_open = 1'b0; m_cnt = 0;
      end
    end
    @(posedge clk);
    #1;
    check("R5 strobe", 32'(res_valid), 32'(exp_v));
    if (exp_v) begin
      check("R3 dc", 32'(res_dc), 32'(exp_dc));
      check("R4 zero word", 32'(res_zero), 32'h0);
    end
    dc_seen = res_dc;
  endtask

  task automatic idle(input int n);
    logic [15:0] d;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, d);
  endtask

  task automatic block_const(input logic [15:0] v, output logic [15:0] d);
    for (int rr = 0; rr < 8; rr++) step(1'b1, rr == 0, fill_row(v), d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    int unsigned seed;
    n_chk = 0; n_fail = 0; done = 1'b0;
    m_open = 1'b0; m_cnt = 0;
    in_valid = 1'b0; in_sop = 1'b0; in_row = '0;
    seed = $urandom(32'h5EED_0DC1);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R1 valid in reset", 32'(res_valid), 32'h0);
    @(negedge clk) rst_n = 1'b1;
    idle(3);
    check("R1 valid after reset", 32'(res_valid), 32'h0);

    // R8: stray rows with no open block are dropped
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, fill_row(16'h1234), d);

    // R2 R3: all ones gives 64
    block_const(16'h0001, d);
    check("R3 all-ones dc", 32'(d), 32'h0040);
    // R2: each column of 0x7FFF wraps to 0xFFF8, total -64
    block_const(16'h7FFF, d);
    check("R2 wrap dc", 32'(d), 32'hFFC0);
    // R2: column of 0x8000 wraps to zero
    block_const(16'h8000, d);
    check("R2 min dc", 32'(d), 32'h0000);
    idle(1);
    check("R5 single cycle", 32'(res_valid), 32'h0);

    // R3: column totals of 0x4000 sum past 16 bits, truncated to 0
    step(1'b1, 1'b1, fill_row(16'h4000), d);
    for (int rr = 1; rr < 8; rr++) step(1'b1, 1'b0, '0, d);
    check("R3 truncation", 32'(d), 32'h0000);

    // R7: gaps between rows
    for (int rr = 0; rr < 8; rr++) begin
      step(1'b1, rr == 0, fill_row(16'(rr + 1)), d);
      idle(rr % 3);
    end
    check("R7 gapped dc", 32'(d), 32'(16'd288));

    // R6: restart after five rows
    for (int rr = 0; rr < 5; rr++) step(1'b1, rr == 0, fill_row(16'h0100), d);
    block_const(16'h0002, d);
    check("R6 restart dc", 32'(d), 32'h0080);

    // R8: stray row right after a block closes, then back-to-back blocks
    step(1'b1, 1'b0, fill_row(16'h7777), d);
    block_const(16'h0003, d);
    block_const(16'hFFFF, d);
    check("R8 back-to-back dc", 32'(d), 32'hFFC0);

    // random traffic
    for (int b = 0; b < 300; b++) begin
      bit s;
      bit v;
      v = ($urandom_range(9) != 0);
      s = m_open ? ($urandom_range(30) == 0) : ($urandom_range(3) != 0);
      step(v, s, rand_row(), d);
    end
    for (int b = 0; b < 60; b++) begin
      for (int rr = 0; rr < 8; rr++) begin
        step(1'b1, rr == 0, rand_row(), d);
        if ($urandom_range(4) == 0) idle(1);
      end
    end
    idle(2);

    // R1: reset mid-block discards it
    for (int rr = 0; rr < 4; rr++) step(1'b1, rr == 0, rand_row(), d);
    @(negedge clk) rst_n = 1'b0;
    m_open = 1'b0; m_cnt = 0;
    @(negedge clk) rst_n = 1'b1;
    for (int rr = 0; rr < 4; rr++) step(1'b1, 1'b0, rand_row(), d);
    check("R1 no block after reset", 32'(res_valid), 32'h0);

    finish_run();
  end
endmodule